// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block collects a parameterised number of interrupt lines (32 by default) and turns them into two request outputs toward a processor, plus one wakeup output. Each line is first synchronised to the controller clock. A three-bit trigger code then chooses how the line is sensed: high level, low level, rising edge, falling edge, either edge, or off. Edge events are held in a per-line latch until software clears them.

Software programs the controller through a small word-addressed register bus. Every control plane has three addresses: a read address, a set alias and a clear alias. The planes are the three trigger-code bits, the enable mask, the wakeup enable, the output routing and the source-connect bit. A write of 1 to a set or clear alias changes only that bit, so each line can be set up without a read-modify-write. Two read-only status words show which enabled lines are pending on each request output. A test word lets software force lines pending.

Top module: `scr_intc`

## Requirements
- R1: After reset every control plane, the edge latches and the test word read as 0, and `req0_o`, `req1_o` and `wake_o` are low.
- R2: Plane p (cfg0=0, cfg1=1, cfg2=2, mask=3, wake=4, route=5, source=6) reads at address 3p. A write to 3p+1 ORs the data into the plane, and a write to 3p+2 clears the bits where the data is 1. Zero bits leave the plane unchanged, and writes to any other address leave the plane as it was.
- R3: With trigger code {cfg2,cfg1,cfg0} = 3'b101 a line is pending while its input is high. With 3'b110 it is pending while its input is low. An input change shows at the outputs after two clock edges.
- R4: Codes 3'b001 (rising), 3'b010 (falling) and 3'b011 (either edge) set the line's edge latch three clock edges after the matching input change. The latch stays set until a 1 is written to that bit at address 23 or address 24. Address 23 reads back the latches.
- R5: Codes 3'b000, 3'b100 and 3'b111 never make a line pending through its input.
- R6: A line whose source-connect bit is 0 is never pending through its input.
- R7: A line drives a request output only while its mask bit is 1.
- R8: Address 21 reads the pending, masked lines whose route bit is 1 (request 0). Address 22 reads those whose route bit is 0 (request 1).
- R9: `req0_o` is high exactly when the address-21 word is non-zero, and `req1_o` exactly when the address-22 word is non-zero.
- R10: `wake_o` is the OR over all lines of pending AND wake enable, whatever the mask holds.
- R11: Address 25 is a plain read/write test word. Each 1 in it makes that line pending, whatever the trigger code and source-connect bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Raw interrupt lines, asynchronous |
| bus_we | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Combinational read data for `bus_addr` |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wakeup output |

## Verification
Some properties are checked on every cycle. The mask plane follows its set and clear aliases and holds otherwise. A held edge latch never drops without a clear. The two status words never share a bit. With an empty mask no request is raised, and with no wake enables no wakeup is raised. Other behaviour only shows up in the bench's scenarios: the exact latency of level and edge detection, the meaning of each trigger code, routing, and the interplay of the test word, the source-connect bit and random register traffic. For these the bench compares the status words and outputs against its own model after each step.

// File: rtl/scr_intc_pkg.sv
package scr_intc_pkg;
  localparam int AW      = 5;
  localparam int NPLANE  = 7;
  localparam int PL_CFG0 = 0;
  localparam int PL_CFG1 = 1;
  localparam int PL_CFG2 = 2;
  localparam int PL_MASK = 3;
  localparam int PL_WAKE = 4;
  localparam int PL_ROUTE = 5;
  localparam int PL_SRC  = 6;

  localparam logic [AW-1:0] A_STAT0 = 5'd21;
  localparam logic [AW-1:0] A_STAT1 = 5'd22;
  localparam logic [AW-1:0] A_RISE  = 5'd23;
  localparam logic [AW-1:0] A_FALL  = 5'd24;
  localparam logic [AW-1:0] A_TEST  = 5'd25;

  function automatic logic [AW-1:0] plane_rd_addr(input int p);
    return AW'(3 * p);
  endfunction

  function automatic logic [AW-1:0] plane_set_addr(input int p);
    return AW'(3 * p + 1);
  endfunction

  function automatic logic [AW-1:0] plane_clr_addr(input int p);
    return AW'(3 * p + 2);
  endfunction

  // Pending from a trigger code, the synchronised level and the edge latch
  function automatic logic trig_active(input logic [2:0] code, input logic lvl,
                                       input logic latched);
    case (code)
      3'b101:                 return lvl;
      3'b110:                 return ~lvl;
      3'b001, 3'b010, 3'b011: return latched;
      default:                return 1'b0;
    endcase
  endfunction

  // Whether the current/previous sample pair is an edge the code asks for
  function automatic logic edge_match(input logic [2:0] code, input logic cur,
                                      input logic prev);
    case (code)
      3'b001:  return cur & ~prev;
      3'b010:  return ~cur & prev;
      3'b011:  return cur ^ prev;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/scr_intc_sync.sv
module scr_intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/scr_intc_regs.sv
module scr_intc_regs
  import scr_intc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [N-1:0]                wdata_i,
  input  logic [N-1:0]                stat0_i,
  input  logic [N-1:0]                stat1_i,
  input  logic [N-1:0]                latch_i,
  output logic [NPLANE-1:0][N-1:0]    plane_o,
  output logic [N-1:0]                test_o,
  output logic [N-1:0]                edge_clr_o,
  output logic [N-1:0]                rdata_o
);
  logic [N-1:0] test_q;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    logic [N-1:0] q;
    logic hit_set, hit_clr;
    assign hit_set = we_i && (addr_i == plane_set_addr(p));
    assign hit_clr = we_i && (addr_i == plane_clr_addr(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (hit_set) q <= q | wdata_i;
      else if (hit_clr) q <= q & ~wdata_i;
    end
    assign plane_o[p] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          test_q <= '0;
    else if (we_i && addr_i == A_TEST)   test_q <= wdata_i;
  end
  assign test_o = test_q;

  assign edge_clr_o = (we_i && (addr_i == A_RISE || addr_i == A_FALL)) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPLANE; p++)
      if (addr_i == plane_rd_addr(p)) rdata_o = plane_o[p];
    case (addr_i)
      A_STAT0: rdata_o = stat0_i;
      A_STAT1: rdata_o = stat1_i;
      A_RISE:  rdata_o = latch_i;
      A_FALL:  rdata_o = latch_i;
      A_TEST:  rdata_o = test_q;
      default: ;
    endcase
  end

  // R2: mask plane follows its aliases and holds otherwise
  a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == plane_set_addr(PL_MASK)) |=>
      (plane_o[PL_MASK] == ($past(plane_o[PL_MASK]) | $past(wdata_i))));
  a_r2_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == plane_clr_addr(PL_MASK)) |=>
      (plane_o[PL_MASK] == ($past(plane_o[PL_MASK]) & ~$past(wdata_i))));
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (addr_i == plane_set_addr(PL_MASK) || addr_i == plane_clr_addr(PL_MASK)))
      |=> $stable(plane_o[PL_MASK]));
endmodule

// File: rtl/scr_intc_detect.sv
module scr_intc_detect
  import scr_intc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] cfg0_i,
  input  logic [N-1:0] cfg1_i,
  input  logic [N-1:0] cfg2_i,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] test_i,
  input  logic [N-1:0] edge_clr_i,
  output logic [N-1:0] latch_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q, latch_q, edge_hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [2:0] code;
    assign code        = {cfg2_i[i], cfg1_i[i], cfg0_i[i]};
    assign edge_hit[i] = edge_match(code, sync_i[i], prev_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i]  <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= sync_i[i];
        if (edge_hit[i])        latch_q[i] <= 1'b1;
        else if (edge_clr_i[i]) latch_q[i] <= 1'b0;
      end
    end

    assign pend_o[i] = (src_i[i] & trig_active(code, sync_i[i], latch_q[i])) | test_i[i];
  end

  assign latch_o = latch_q;

  // R4: a held edge latch only drops through a clear write
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(latch_q) & ~$past(edge_clr_i)) & ~latch_q) == '0));
endmodule

// File: rtl/scr_intc.sv
module scr_intc
  import scr_intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  logic [NPLANE-1:0][NSRC-1:0] planes;
  logic [NSRC-1:0] sync_w, test_w, edge_clr_w, latch_w, pend_w;
  logic [NSRC-1:0] stat0_w, stat1_w;

  scr_intc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_in), .q_o(sync_w)
  );

  scr_intc_regs #(.N(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .stat0_i(stat0_w), .stat1_i(stat1_w),
    .latch_i(latch_w), .plane_o(planes), .test_o(test_w),
    .edge_clr_o(edge_clr_w), .rdata_o(bus_rdata)
  );

  scr_intc_detect #(.N(NSRC)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_w),
    .cfg0_i(planes[PL_CFG0]), .cfg1_i(planes[PL_CFG1]), .cfg2_i(planes[PL_CFG2]),
    .src_i(planes[PL_SRC]), .test_i(test_w), .edge_clr_i(edge_clr_w),
    .latch_o(latch_w), .pend_o(pend_w)
  );

  assign stat0_w = pend_w & planes[PL_MASK] &  planes[PL_ROUTE];
  assign stat1_w = pend_w & planes[PL_MASK] & ~planes[PL_ROUTE];
  assign req0_o  = |stat0_w;
  assign req1_o  = |stat1_w;
  assign wake_o  = |(pend_w & planes[PL_WAKE]);

  // R7: nothing requests with an empty mask
  a_r7_mask_gates_req: assert property (@(posedge clk) disable iff (!rst_n)
    (planes[PL_MASK] == '0) |-> (!req0_o && !req1_o));
  // R8: a line is routed to exactly one output
  a_r8_status_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat0_w & stat1_w) == '0));
  // R10: wakeup needs at least one wake enable
  a_r10_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (planes[PL_WAKE] != '0));
endmodule

// File: tb/sim_scr_intc.sv
module sim_scr_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req0, req1, wake;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [31:0] mp [7];
  logic [31:0] m_latch, m_test;

  always #4 clk = ~clk;

  scr_intc #(.NSRC(32)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .req0_o(req0), .req1_o(req1), .wake_o(wake)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // bus write plus model update
  task automatic put(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
    if (a < 5'd21) begin
      if (a % 3 == 1) mp[a/3] = mp[a/3] | d;
      else if (a % 3 == 2) mp[a/3] = mp[a/3] & ~d;
    end else if (a == 5'd23 || a == 5'd24) m_latch = m_latch & ~d;
    else if (a == 5'd25) m_test = d;
  endtask

  function automatic logic [2:0] code_of(input int i);
    return {mp[2][i], mp[1][i], mp[0][i]};
  endfunction

  function automatic logic m_pend(input int i);
    logic [2:0] c;
    logic t;
    c = code_of(i);
    t = 1'b0;
    if (c == 3'b101) t = irq[i];
    if (c == 3'b110) t = !irq[i];
    if (c == 3'b001 || c == 3'b010 || c == 3'b011) t = m_latch[i];
    return (mp[6][i] && t) || m_test[i];
  endfunction

  function automatic logic [31:0] m_stat(input bit which);
    logic [31:0] s;
    for (int i = 0; i < 32; i++)
      s[i] = m_pend(i) && mp[3][i] && (mp[5][i] == !which);
    return s;
  endfunction

  function automatic logic m_wake();
    logic w;
    w = 1'b0;
    for (int i = 0; i < 32; i++) w = w | (m_pend(i) && mp[4][i]);
    return w;
  endfunction

  task automatic drive_irq(input logic [31:0] v);
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      logic [2:0] c;
      c = code_of(i);
      if ((c == 3'b001 && !irq[i] && v[i]) || (c == 3'b010 && irq[i] && !v[i]) ||
          (c == 3'b011 && irq[i] != v[i]))
        m_latch[i] = 1'b1;
    end
    irq = v;
  endtask

  task automatic check_outs(input string tag);
    logic [31:0] d;
    rd(5'd21, d); chk({tag, " R8 stat0"}, d, m_stat(0));
    rd(5'd22, d); chk({tag, " R8 stat1"}, d, m_stat(1));
    chk({tag, " R9 req0"}, {31'd0, req0}, {31'd0, |m_stat(0)});
    chk({tag, " R9 req1"}, {31'd0, req1}, {31'd0, |m_stat(1)});
    chk({tag, " R10 wake"}, {31'd0, wake}, {31'd0, m_wake()});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    for (int p = 0; p < 7; p++) mp[p] = '0;
    m_latch = '0; m_test = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int p = 0; p < 7; p++) begin
      rd(5'(3 * p), d); chk("R1 plane", d, '0);
    end
    rd(5'd23, d); chk("R1 latch", d, '0);
    rd(5'd25, d); chk("R1 test", d, '0);
    chk("R1 outputs", {29'd0, req0, req1, wake}, '0);

    // R2 set/clear aliases
    put(5'd10, 32'h0000_F0F0);
    put(5'd10, 32'h0000_0F00);
    rd(5'd9, d); chk("R2 mask set", d, 32'h0000_FFF0);
    put(5'd11, 32'h0000_00F0);
    rd(5'd9, d); chk("R2 mask clr", d, 32'h0000_FF00);
    put(5'd22, 32'hFFFF_FFFF);
    rd(5'd9, d); chk("R2 other addr", d, 32'h0000_FF00);
    put(5'd11, 32'hFFFF_FFFF);

    // R3 high level on line 3, routed to request 0
    put(5'd7, 32'h8); put(5'd1, 32'h8); put(5'd19, 32'h8);
    put(5'd10, 32'h8); put(5'd16, 32'h8);
    @(negedge clk); irq[3] = 1'b1;
    @(negedge clk); chk("R3 one edge", {31'd0, req0}, 32'd0);
    @(negedge clk); chk("R3 two edges", {31'd0, req0}, 32'd1);
    check_outs("R3 high");
    // R8 reroute to request 1
    put(5'd17, 32'h8);
    check_outs("R8 reroute");
    // R7 mask off removes request; R10 wake still follows pending
    put(5'd13, 32'h8); put(5'd11, 32'h8);
    chk("R7 masked", {30'd0, req0, req1}, 32'd0);
    chk("R10 wake unmasked", {31'd0, wake}, 32'd1);
    // R6 disconnect source
    put(5'd20, 32'h8);
    chk("R6 source off", {31'd0, wake}, 32'd0);
    put(5'd19, 32'h8); put(5'd10, 32'h8);
    // R5 code 000 and 100 never pending
    put(5'd2, 32'h8);
    check_outs("R5 code100");
    put(5'd8, 32'h8);
    check_outs("R5 code000");
    // R3 low level: code 110, input low
    put(5'd7, 32'h8); put(5'd4, 32'h8);
    drive_irq(32'h0);
    repeat (2) @(negedge clk);
    chk("R3 low level", {31'd0, req1}, 32'd1);

    // R4 rising edge on line 5
    put(5'd8, 32'h8); put(5'd5, 32'h8);
    put(5'd1, 32'h20); put(5'd19, 32'h20); put(5'd10, 32'h20); put(5'd16, 32'h20);
    drive_irq(32'h20);
    @(negedge clk); @(negedge clk);
    chk("R4 two edges", {31'd0, req0}, 32'd0);
    @(negedge clk);
    chk("R4 three edges", {31'd0, req0}, 32'd1);
    drive_irq(32'h0);
    repeat (4) @(negedge clk);
    rd(5'd23, d); chk("R4 latch held", d, 32'h20);
    put(5'd23, 32'h20);
    rd(5'd23, d); chk("R4 latch cleared", d, 32'h0);
    check_outs("R4 after clear");

    // R11 test word
    put(5'd25, 32'h8000_0000); put(5'd10, 32'h8000_0000);
    rd(5'd25, d); chk("R11 readback", d, 32'h8000_0000);
    check_outs("R11 forced");

    // Random phase, model starts from a clean state
    for (int p = 0; p < 7; p++) put(5'(3 * p + 2), 32'hFFFF_FFFF);
    put(5'd25, 32'h0);
    drive_irq(32'h0);
    repeat (4) @(negedge clk);
    put(5'd24, 32'hFFFF_FFFF);
    for (int it = 0; it < 200; it++) begin
      logic [4:0] a;
      int p;
      drive_irq($urandom);
      repeat (4) @(negedge clk);
      a = 5'($urandom % 26);
      d = $urandom & $urandom;
      put(a, d);
      check_outs("rand R3 R4 R7");
      p = $urandom % 7;
      rd(5'(3 * p), d); chk("rand R2 plane", d, mp[p]);
      rd(5'd23, d); chk("rand R4 latch", d, m_latch);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule